// File: doc/BRIEF.md
# Triple-Mode Serializer Data Router

This block sits between a quarter-rate parallel data path and a segmented line driver that has a heavy (MSB) segment and a light (LSB) segment. It takes one four-bit word per transfer, together with a two-bit mode select. It then emits that word one output symbol at a time, as an MSB/LSB bit pair per cycle.

Three line codes are supported. In binary mode the raw bits go out one per symbol, and both segments carry the same bit. In four-level mode two raw bits form each symbol: the even-indexed bit goes to the MSB segment and the odd-indexed bit to the LSB segment, so a word takes only two symbols. In duobinary mode every bit first passes through a running XOR precoder, and the coded bit then goes to both segments.

Serialization is built as two cascaded 2:1 selections. The first selection picks a bit pair out of the word. The second picks within that pair, or, in four-level mode, splits the pair across the two segments. The mode is captured together with the word. A new word is taken only in the cycle that emits the last symbol of the current word, or when the block is idle, so consecutive words stream without gaps.

Top module: `tm_ser_router`

## Requirements
- R1: The mode select uses 2'b00 for binary, 2'b01 for four-level and 2'b10 for duobinary; the code 2'b11 behaves exactly like binary.
- R2: In binary mode a word produces four symbols in the order bit 0, bit 1, bit 2, bit 3, with sym_msb and sym_lsb both equal to the raw bit.
- R3: In four-level mode a word produces two symbols: first sym_msb = bit 0 and sym_lsb = bit 1, then sym_msb = bit 2 and sym_lsb = bit 3.
- R4: In duobinary mode a word produces four symbols in bit order, with sym_msb = sym_lsb = x, where x(n) = d(n) XOR x(n-1). The previous coded bit x(n-1) carries across duobinary words and is 0 after reset.
- R5: Binary and four-level words leave the precoder history unchanged, so the next duobinary word continues from the last coded bit of the previous duobinary word.
- R6: A word is accepted at a rising edge where word_valid and word_ready are both high. word_ready is high when the block is idle or is emitting the last symbol of a word, and low otherwise. The first symbol of an accepted word appears in the following cycle.
- R7: sym_valid is high for exactly one cycle per symbol, and the symbols of one word occupy consecutive cycles.
- R8: The mode is sampled only when a word is accepted; changing mode_sel while a word is being emitted has no effect on that word.
- R9: While reset is asserted and right after it, word_ready is high and sym_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | A word is offered |
| word_data | input | 4 | Parallel word, bit 0 sent first |
| mode_sel | input | 2 | Line code select |
| word_ready | output | 1 | Block can take a word at this edge |
| sym_valid | output | 1 | sym_msb/sym_lsb hold a symbol |
| sym_msb | output | 1 | Bit for the heavy driver segment |
| sym_lsb | output | 1 | Bit for the light driver segment |

## Verification
The binary words 0000, 1111 and 1010 separate bit order from a stuck or swapped segment. In four-level mode, 0110 and 1001 reveal any swap between even and odd bits or between the two pairs. Duobinary words are sent in a chain, with binary and four-level words placed between them, to show that the coded history runs across words and is left alone by the other modes. Further patterns check that code 11 is treated as binary, that a mode change in the middle of a word has no effect, and that words streamed back to back keep their order without gaps.

// File: rtl/tm_ser_router.sv
module tm_ser_router #(
  parameter int WORD_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 word_valid,
  input  logic [WORD_BITS-1:0] word_data,
  input  logic [1:0]           mode_sel,
  output logic                 word_ready,
  output logic                 sym_valid,
  output logic                 sym_msb,
  output logic                 sym_lsb
);
  localparam int CW = $clog2(WORD_BITS);

  logic                 busy;
  logic [CW-1:0]        cnt;
  logic [WORD_BITS-1:0] hold;
  logic                 four_q;
  logic                 hist;
  logic [WORD_BITS-1:0] coded;
  logic                 last;
  logic                 take;
  logic [1:0]           pair;
  logic                 pick;

  always_comb begin
    coded[0] = word_data[0] ^ hist;
    for (int i = 1; i < WORD_BITS; i++) coded[i] = word_data[i] ^ coded[i-1];
  end

  assign last       = four_q ? (cnt == CW'(WORD_BITS/2 - 1)) : (cnt == CW'(WORD_BITS - 1));
  assign word_ready = !busy || last;
  assign take       = word_valid && word_ready;
  assign sym_valid  = busy;

  // stage one: pair select; stage two: bit select or segment split
  assign pair    = four_q ? hold[{cnt[0], 1'b0} +: 2] : hold[{cnt[CW-1:1], 1'b0} +: 2];
  assign pick    = cnt[0] ? pair[1] : pair[0];
  assign sym_msb = four_q ? pair[0] : pick;
  assign sym_lsb = four_q ? pair[1] : pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      hold   <= '0;
      four_q <= 1'b0;
      hist   <= 1'b0;
    end else if (take) begin
      busy   <= 1'b1;
      cnt    <= '0;
      four_q <= (mode_sel == 2'b01);
      if (mode_sel == 2'b10) begin
        hold <= coded;
        hist <= coded[WORD_BITS-1];
      end else begin
        hold <= word_data;
      end
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  assert_binary_segments_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !four_q) |-> (sym_msb == sym_lsb));

  assert_accept_starts_symbols_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (sym_valid && cnt == '0));

  assert_no_ready_midword_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !last) |-> !word_ready);

  assert_contiguous_symbols_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !last) |=> (sym_valid && cnt == $past(cnt) + 1'b1));

  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !last) |=> $stable(four_q) && $stable(hold));

  assert_hist_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode_sel != 2'b10) |=> $stable(hist));
endmodule

// File: tb/tm_ser_router_tb.sv
`timescale 1ns/1ps
module tm_ser_router_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_valid = 1'b0;
  logic [3:0] word_data = '0;
  logic [1:0] mode_sel = '0;
  logic word_ready, sym_valid, sym_msb, sym_lsb;

  int checks = 0;
  int fails = 0;
  bit tb_hist = 1'b0;
  bit done = 1'b0;
  logic [1:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  tm_ser_router dut_i (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .mode_sel(mode_sel), .word_ready(word_ready), .sym_valid(sym_valid),
    .sym_msb(sym_msb), .sym_lsb(sym_lsb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic push_expect(input logic [1:0] m, input logic [3:0] d);
    if (m == 2'b01) begin
      exp_q.push_back({d[0], d[1]}); tag_q.push_back("R3");
      exp_q.push_back({d[2], d[3]}); tag_q.push_back("R3");
    end else if (m == 2'b10) begin
      for (int i = 0; i < 4; i++) begin
        tb_hist = d[i] ^ tb_hist;
        exp_q.push_back({tb_hist, tb_hist}); tag_q.push_back("R4/R5");
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        exp_q.push_back({d[i], d[i]});
        tag_q.push_back(m == 2'b11 ? "R1" : "R2");
      end
    end
  endtask

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic send(input logic [1:0] m, input logic [3:0] d);
    word_valid = 1'b1; word_data = d; mode_sel = m;
    while (!word_ready) @(negedge clk);
    push_expect(m, d);
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || sym_valid) && guard < 50) begin
      @(negedge clk); guard++;
    end
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && sym_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", {sym_msb, sym_lsb}, -1);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({sym_msb, sym_lsb} == e, t, {sym_msb, sym_lsb}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    @(negedge clk);
    check(word_ready == 1'b1, "R9 ready in reset", word_ready, 1);
    check(sym_valid == 1'b0, "R9 valid in reset", sym_valid, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(word_ready == 1'b1 && sym_valid == 1'b0, "R9 after reset", {word_ready, sym_valid}, 2);

    send(2'b00, 4'b0000); drain();
    send(2'b00, 4'b1111); drain();
    send(2'b00, 4'b1010);
    check(sym_valid == 1'b1, "R6 first symbol next cycle", sym_valid, 1);
    check(word_ready == 1'b0, "R6 ready low mid-word", word_ready, 0);
    drain();
    check(sym_valid == 1'b0, "R7 idle after word", sym_valid, 0);

    send(2'b01, 4'b0110); drain();
    send(2'b01, 4'b1001); drain();

    send(2'b10, 4'b1011); drain();
    send(2'b00, 4'b1101); drain();
    send(2'b01, 4'b0111); drain();
    send(2'b10, 4'b0000); drain();
    send(2'b10, 4'b1111); drain();

    send(2'b11, 4'b0110); drain();

    // R8: mode toggles while a word is emitted
    send(2'b01, 4'b1100);
    mode_sel = 2'b10;
    @(negedge clk);
    mode_sel = 2'b00;
    drain();
    send(2'b00, 4'b0011);
    mode_sel = 2'b01;
    @(negedge clk);
    mode_sel = 2'b10;
    drain();

    // back-to-back stream, mixed modes, gap-free count check
    begin
      int vcount = 0;
      fork
        begin
          send(2'b10, 4'b0101);
          send(2'b01, 4'b0011);
          send(2'b00, 4'b1001);
          send(2'b10, 4'b1110);
        end
        begin
          @(negedge clk);
          for (int i = 0; i < 14; i++) begin
            if (sym_valid) vcount++;
            @(negedge clk);
          end
        end
      join
      check(vcount == 14, "R7 back-to-back gap-free", vcount, 14);
    end
    drain();
    check(exp_q.size() == 0, "R7 all symbols emitted", exp_q.size(), 0);

    done = 1'b1;
    summary();
  end
endmodule